// File: doc/BRIEF.md
# Multi-Mode Serial Bit-Rate Clock Generator

This block derives all bit-rate timing for a serial port from the system clock. A 12-bit programmable prescaler divides the clock by (DIV + 1). A mode-dependent post-divider then turns prescaler ticks into one transmitter tick per bit. The post-divider counts 16 ticks in asynchronous normal mode, 8 in asynchronous double-speed mode and 2 in synchronous master mode.

In the asynchronous modes every prescaler tick is also handed to the receiver as an oversampling tick. A count output tells the receiver how many samples make up one bit. In synchronous master mode the block drives a square serial clock instead; that clock toggles on each prescaler tick.

Changing the divider value or the effective mode restarts all counters, so the new rate starts from a clean period. The double-speed select counts only in the asynchronous modes.

Top module: `baud_clkgen`

## Requirements
- R1: Asynchronous normal mode (sync_mode=0, dbl_speed=0): os_tick pulses once every DIV+1 cycles and tx_tick once every 16×(DIV+1) cycles; every tx_tick coincides with an os_tick.
- R2: Asynchronous double-speed mode (sync_mode=0, dbl_speed=1): os_tick pulses once every DIV+1 cycles and tx_tick once every 8×(DIV+1) cycles.
- R3: Synchronous master mode (sync_mode=1): tx_tick pulses once every 2×(DIV+1) cycles, and sclk toggles once every DIV+1 cycles, giving a square clock of period 2×(DIV+1).
- R4: div_val accepts the full range 0 to 4095. With DIV=0 the prescaler ticks on every cycle; with DIV=4095 the periods above hold with DIV+1=4096.
- R5: With sync_mode=1, dbl_speed has no effect. samples_per_bit stays 16, the periods of R3 hold, and toggling dbl_speed while running does not disturb the tick or sclk timing.
- R6: samples_per_bit reads 16 in asynchronous normal mode and 8 in asynchronous double-speed mode.
- R7: A change of div_val or of the effective mode, first presented in cycle 0, restarts every counter. No tick appears in cycle 0, the first prescaler tick comes in cycle DIV+1 and the first tx_tick in cycle M×(DIV+1), where M is 16, 8 or 2. sclk is low from cycle 1 until its first toggle.
- R8: While rst_n is low, os_tick, tx_tick and sclk are all 0. The cycle in which reset is first seen released behaves as cycle 0 of R7.
- R9: In the asynchronous modes sclk is held low, from the cycle after entering such a mode. In synchronous mode os_tick never pulses.
- R10: tx_tick is a single-cycle pulse; it is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_val | input | 12 | Prescaler divider value DIV (0..4095) |
| dbl_speed | input | 1 | Double-speed select (asynchronous modes only) |
| sync_mode | input | 1 | 1 selects synchronous master mode |
| os_tick | output | 1 | Receiver oversampling tick (asynchronous modes) |
| tx_tick | output | 1 | Transmitter bit tick, one cycle wide |
| sclk | output | 1 | Synchronous master serial clock |
| samples_per_bit | output | 5 | Receiver samples per bit (16 or 8) |

## Verification
The following relations are checked on every cycle by assertions:
- tx_tick is one cycle wide and, in the asynchronous modes, falls on an os_tick.
- os_tick is silent in synchronous mode.
- samples_per_bit follows the mode.
- sclk stays low in the asynchronous modes and rises only in synchronous mode.
- all outputs are quiet during reset.

The exact periods per mode, the restart timing after a change, the continuity when dbl_speed flips in synchronous mode and the limits DIV=0 and DIV=4095 span many cycles. Only the bench's directed and random scenarios can show these, by comparing every cycle against an expected pattern.

// File: rtl/baud_pkg.sv
package baud_pkg;

  localparam int PCW   = 4;  // post-divider counter width (largest modulus 16)
  localparam int SPB_W = 5;  // samples-per-bit output width

  typedef enum logic [1:0] {
    MODE_NORM = 2'd0,
    MODE_DBL  = 2'd1,
    MODE_SYNC = 2'd2
  } rate_mode_e;

  // terminal count of the post-divider (modulus - 1)
  function automatic logic [PCW-1:0] post_last(input rate_mode_e m);
    case (m)
      MODE_DBL:  post_last = PCW'(7);
      MODE_SYNC: post_last = PCW'(1);
      default:   post_last = PCW'(15);
    endcase
  endfunction

  function automatic logic [SPB_W-1:0] spb_of(input rate_mode_e m);
    spb_of = (m == MODE_DBL) ? SPB_W'(8) : SPB_W'(16);
  endfunction

endpackage

// File: rtl/baud_prescaler.sv
module baud_prescaler #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  input  logic [W-1:0] reload,
  output logic         tick
);

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    tick   = 1'b0;
    cnt_en = 1'b1;
    cnt_d  = cnt_q;
    if (restart) begin
      cnt_d = reload;
    end else if (cnt_q == '0) begin
      tick  = 1'b1;
      cnt_d = reload;
    end else begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/baud_postdiv.sv
module baud_postdiv #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          step,
  input  logic [CW-1:0] last,
  output logic          wrap
);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = restart | step;
    wrap   = step & ~restart & (cnt_q == last);
    if (restart || wrap) cnt_d = '0;
    else                 cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/baud_sclk_gen.sv
module baud_sclk_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic active,
  input  logic step,
  output logic sclk
);

  logic sclk_q, sclk_d, sclk_en;

  always_comb begin
    sclk_en = restart | ~active | step;
    if (restart || !active) sclk_d = 1'b0;
    else                    sclk_d = ~sclk_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sclk_q <= 1'b0;
    else if (sclk_en) sclk_q <= sclk_d;
  end

  assign sclk = sclk_q;

endmodule

// File: rtl/baud_clkgen.sv
module baud_clkgen
  import baud_pkg::*;
#(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_val,
  input  logic             dbl_speed,
  input  logic             sync_mode,
  output logic             os_tick,
  output logic             tx_tick,
  output logic             sclk,
  output logic [SPB_W-1:0] samples_per_bit
);

  rate_mode_e       mode_now, mode_q;
  logic [DIV_W-1:0] div_q;
  logic             run_q;
  logic             restart;
  logic             pre_tick;

  // effective mode: double speed only counts outside synchronous mode
  always_comb begin
    if (sync_mode)      mode_now = MODE_SYNC;
    else if (dbl_speed) mode_now = MODE_DBL;
    else                mode_now = MODE_NORM;
  end

  assign restart = ~run_q | (div_val != div_q) | (mode_now != mode_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      div_q  <= '0;
      mode_q <= MODE_NORM;
    end else begin
      run_q  <= 1'b1;
      div_q  <= div_val;
      mode_q <= mode_now;
    end
  end

  baud_prescaler #(.W(DIV_W)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .reload  (div_val),
    .tick    (pre_tick)
  );

  baud_postdiv #(.CW(PCW)) u_post (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .step    (pre_tick),
    .last    (post_last(mode_now)),
    .wrap    (tx_tick)
  );

  baud_sclk_gen u_sclk (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .active  (mode_now == MODE_SYNC),
    .step    (pre_tick),
    .sclk    (sclk)
  );

  assign os_tick         = pre_tick & (mode_now != MODE_SYNC);
  assign samples_per_bit = spb_of(mode_now);

endmodule

// File: rtl/baud_clkgen_chk.sv
module baud_clkgen_chk #(
  parameter int DIV_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic [DIV_W-1:0] div_val,
  input logic             dbl_speed,
  input logic             sync_mode,
  input logic             os_tick,
  input logic             tx_tick,
  input logic             sclk,
  input logic [4:0]       samples_per_bit
);

  p_reset_quiet_r8: assert property (@(posedge clk)
    !rst_n |-> (!os_tick && !tx_tick && !sclk));

  p_tx_on_os_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_tick && !sync_mode) |-> os_tick);

  p_tx_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_tick |=> !tx_tick);

  p_dbl_spb_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_mode && dbl_speed) |-> (samples_per_bit == 5'd8));

  p_norm_spb_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_mode && !dbl_speed) |-> (samples_per_bit == 5'd16));

  p_sync_ignores_dbl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sync_mode |-> (samples_per_bit == 5'd16 && !os_tick));

  p_async_sclk_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_mode && $past(!sync_mode)) |-> !sclk);

  p_sclk_rise_sync_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> $past(sync_mode));

endmodule

bind baud_clkgen baud_clkgen_chk #(.DIV_W(DIV_W)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .div_val         (div_val),
  .dbl_speed       (dbl_speed),
  .sync_mode       (sync_mode),
  .os_tick         (os_tick),
  .tx_tick         (tx_tick),
  .sclk            (sclk),
  .samples_per_bit (samples_per_bit)
);

// File: tb/sim_baud_clkgen.sv
module sim_baud_clkgen;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] div_val;
  logic        dbl_speed;
  logic        sync_mode;
  logic        os_tick, tx_tick, sclk;
  logic [4:0]  samples_per_bit;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #(CLK_P/2) clk = ~clk;

  baud_clkgen u0 (
    .clk(clk), .rst_n(rst_n), .div_val(div_val), .dbl_speed(dbl_speed),
    .sync_mode(sync_mode), .os_tick(os_tick), .tx_tick(tx_tick),
    .sclk(sclk), .samples_per_bit(samples_per_bit)
  );

  function automatic int post_mod(input bit dbl, input bit syn);
    if (syn) return 2;
    return dbl ? 8 : 16;
  endfunction

  function automatic int exp_spb(input bit dbl, input bit syn);
    return (!syn && dbl) ? 8 : 16;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Entered at a negedge where the cycle index is cstart (0 = first cycle
  // a new setting or reset release is seen). Compares every cycle up to cend.
  task automatic run_cfg(input int d, input bit dbl, input bit syn,
                         input int cstart, input int cend, input string req);
    int m = post_mod(dbl, syn);
    int bad_os = 0, bad_tx = 0, bad_sc = 0, bad_sp = 0;
    int f_os = -1, f_tx = -1, f_sc = -1;
    for (int c = cstart; c <= cend; c++) begin
      bit ept, eos, etx, esc;
      #(CLK_P/2 - 1);
      ept = (c > 0) && (c % (d + 1) == 0);
      eos = ept && !syn;
      etx = (c > 0) && (c % (m * (d + 1)) == 0);
      esc = syn ? bit'(((c - 1) / (d + 1)) % 2) : 1'b0;
      if (os_tick !== eos) begin bad_os++; if (f_os < 0) f_os = c; end
      if (tx_tick !== etx) begin bad_tx++; if (f_tx < 0) f_tx = c; end
      if (c > 0 && sclk !== esc) begin bad_sc++; if (f_sc < 0) f_sc = c; end
      if (samples_per_bit !== 5'(exp_spb(dbl, syn))) bad_sp++;
      @(negedge clk);
    end
    check(bad_os == 0, req, $sformatf("os_tick mismatches d=%0d dbl=%0d sync=%0d first_cycle=%0d",
          d, dbl, syn, f_os), bad_os, 0);
    check(bad_tx == 0, req, $sformatf("tx_tick mismatches d=%0d dbl=%0d sync=%0d first_cycle=%0d",
          d, dbl, syn, f_tx), bad_tx, 0);
    check(bad_sc == 0, req, $sformatf("sclk mismatches d=%0d dbl=%0d sync=%0d first_cycle=%0d",
          d, dbl, syn, f_sc), bad_sc, 0);
    check(bad_sp == 0, req, $sformatf("samples_per_bit mismatches (exp %0d)",
          exp_spb(dbl, syn)), bad_sp, 0);
  endtask

  task automatic apply(input int d, input bit dbl, input bit syn);
    div_val   = 12'(d);
    dbl_speed = dbl;
    sync_mode = syn;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 190000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int pd, pb, ps;
    int seed_val;
    rst_n = 1'b0;
    apply(3, 0, 0);
    // R8: quiet during reset
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      #(CLK_P/2 - 1);
      check(!os_tick && !tx_tick && !sclk, "R8", "outputs during reset",
            {29'd0, os_tick, tx_tick, sclk}, 0);
    end
    @(negedge clk);
    rst_n = 1'b1;
    run_cfg(3, 0, 0, 0, 2 * 16 * 4, "R8 R1");   // release cycle acts as cycle 0

    // R1 / R2 / R3 directed, R7 via mid-period changes
    idle(5);  apply(5, 1, 0); run_cfg(5, 1, 0, 0, 2 * 8 * 6, "R2 R7");
    idle(3);  apply(5, 0, 1); run_cfg(5, 0, 1, 0, 4 * 2 * 6, "R3 R7");
    idle(2);  apply(7, 0, 0); run_cfg(7, 0, 0, 0, 2 * 16 * 8, "R1 R7 R9");

    // R4: DIV = 0 in every mode, DIV = 4095 in fast modes
    idle(1);  apply(0, 0, 0); run_cfg(0, 0, 0, 0, 48, "R4 R1");
    apply(0, 1, 0);           run_cfg(0, 1, 0, 0, 24, "R4 R2");
    apply(0, 0, 1);           run_cfg(0, 0, 1, 0, 12, "R4 R3");
    apply(4095, 0, 1);        run_cfg(4095, 0, 1, 0, 2 * 4096, "R4 R3");
    apply(4095, 1, 0);        run_cfg(4095, 1, 0, 0, 8 * 4096, "R4 R2");

    // R5: dbl_speed ignored in synchronous mode, including a mid-run flip
    apply(2, 1, 1);           run_cfg(2, 1, 1, 0, 2 * 2 * 3, "R5");
    apply(2, 0, 1);           run_cfg(2, 0, 1, 13, 13 + 16, "R5 continuity");
    dbl_speed = 1'b1;         run_cfg(2, 1, 1, 30, 30 + 20, "R5 continuity");

    // R6 / R10 / R7: random settings, fixed seed, each differing from the last
    seed_val = 32'd20240613;
    void'($urandom(seed_val));
    pd = 2; pb = 1; ps = 1;
    for (int k = 0; k < 16; k++) begin
      int d  = int'($urandom % 48);
      bit b  = bit'($urandom % 2);
      bit s  = bit'($urandom % 2);
      int nt = 1 + int'($urandom % 2);
      int gap = int'($urandom % 6);
      if (d == pd && s == ps && (s || b == pb)) d = (d + 1) % 48;
      idle(gap);
      apply(d, b, s);
      run_cfg(d, b, s, 0, nt * post_mod(b, s) * (d + 1), "R6 R7 R10");
      pd = d; pb = b; ps = s;
    end

    finish_run();
  end

endmodule